// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block derives the bit clock of a synchronous serial master from the system clock. Two cascaded counters do the division. The first is an even prescaler and the second is a programmable rate stage. The serial clock therefore changes level once every (P/2)·(1+R) system cycles, where P is the effective prescale value and R is the rate value. The bit rate is the system clock divided by P·(1+R). This covers a range from half the system clock down to one part in 254·256 of it.

A frame starts when the run request is seen while the block is idle. At that moment the block captures the prescale value, the rate value, the clock polarity, the clock phase and the frame length. Both counters restart from zero, so the first clock edge of every frame lands at a fixed distance from the start. During the frame the block toggles the serial clock 2·N times for an N-bit frame. With each toggle it emits single-cycle strobes that tell a shift register when to launch the next bit and when to capture the incoming one. It also marks the end of every bit and the end of the frame. When no frame is active, the serial clock rests at the polarity level.

Top module: `sclk_gen`

## Requirements
- R1: While reset is held, sclk_o, busy_o and every strobe output are 0.
- R2: While busy_o is 0, sclk_o takes the value cpol_i had on the previous clock edge, and no strobe is raised.
- R3: When start_i is accepted at edge 0, sclk_o changes level at edge k·H for k = 1..2N and at no other edge, where H = (P/2)·(1+rate_i) system cycles. busy_o is 1 from edge 1 until edge 2N·H, at which point it drops.
- R4: The effective prescale P is prescale_i with bit 0 forced to 0. An input of 0 or 1 counts as 2.
- R5: The frame length N is bits_i clamped to the range 4..16. done_o pulses for one cycle together with the 2N-th sclk transition, and at that point sclk_o is back at the captured polarity.
- R6: Transitions of sclk_o are numbered 1..2N, and odd numbers are leading edges. With cpha_i = 0, sample_o fires on leading edges and launch_o fires on trailing edges other than the last. With cpha_i = 1, launch_o fires on leading edges and sample_o fires on trailing edges.
- R7: bit_tick_o fires on every trailing transition, which gives N pulses per frame.
- R8: While busy_o is 1, start_i and changes to prescale_i, rate_i, cpol_i, cpha_i or bits_i have no effect on the running frame.
- R9: Each strobe lasts one cycle, it coincides with an sclk_o transition, and launch_o and sample_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_i | input | PRE_W | First-stage divisor (even, 2..254) |
| rate_i | input | RATE_W | Second-stage divisor minus one |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| bits_i | input | LEN_W | Bits per frame, clamped to 4..16 |
| start_i | input | 1 | Run request, accepted only when idle |
| sclk_o | output | 1 | Serial clock level |
| launch_o | output | 1 | Strobe: shift out next bit |
| sample_o | output | 1 | Strobe: capture incoming bit |
| bit_tick_o | output | 1 | Strobe: end of a bit period |
| done_o | output | 1 | Strobe: last edge of the frame |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default widths: 8-bit prescale, 8-bit rate and a 5-bit length field. With these widths it can drive both divider extremes, a prescale of 254 and a rate of 255, as well as the fastest setting of half the system clock. The 5-bit length field also lets the bench request lengths below 4 and above 16, so the clamp is exercised on both sides. Each frame is compared cycle by cycle against a model built only from H and N, for all four polarity and phase combinations. One frame receives a start request and altered settings partway through.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    localparam int PRE_W_DEF  = 8;
    localparam int RATE_W_DEF = 8;
    localparam int LEN_W_DEF  = 5;
    localparam int MIN_BITS   = 4;
    localparam int MAX_BITS   = 16;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic launch;
        logic sample;
        logic tick;
        logic done;
    } strobe_t;

    // Half of the even prescale value; bit 0 dropped, never below one.
    function automatic logic [15:0] half_prescale(input logic [15:0] pre);
        logic [15:0] h;
        h = pre >> 1;
        if (h == 16'd0) h = 16'd1;
        return h;
    endfunction

    // Number of clock transitions in a frame after clamping the length.
    function automatic logic [7:0] edge_total(input logic [7:0] bits);
        logic [7:0] n;
        n = bits;
        if (n < 8'(MIN_BITS))      n = 8'(MIN_BITS);
        else if (n > 8'(MAX_BITS)) n = 8'(MAX_BITS);
        return n << 1;
    endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              tick_o
);
    logic [HALF_W-1:0] cnt;

    assign tick_o = run_i && (cnt == half_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run_i)  cnt <= '0;
        else if (tick_o)    cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt < half_i)); // R3

endmodule

// File: rtl/sclk_rate.sv
module sclk_rate #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              step_i,
    input  logic [RATE_W-1:0] limit_i,
    output logic              edge_o
);
    logic [RATE_W-1:0] cnt;

    assign edge_o = run_i && step_i && (cnt == limit_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i)  cnt <= '0;
        else if (edge_o)    cnt <= '0;
        else if (step_i)    cnt <= cnt + 1'b1;
    end

    AST_RATE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt <= limit_i)); // R3

endmodule

// File: rtl/sclk_edge_seq.sv
module sclk_edge_seq
    import sclk_gen_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [LEN_W-1:0] bits_i,
    input  logic             edge_i,
    output logic             busy_o,
    output logic             sclk_o,
    output strobe_t          strobe_o
);
    localparam int EDGE_W = LEN_W + 1;

    phase_e            ph;
    logic              cpol_q, cpha_q;
    logic [EDGE_W-1:0] total_q, total_d, ecnt, nxt;
    logic              leading, last;

    assign total_d = EDGE_W'(edge_total(8'(bits_i)));
    assign nxt     = ecnt + 1'b1;
    assign leading = nxt[0];
    assign last    = (nxt == total_q);
    assign busy_o  = (ph == PH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            sclk_o   <= 1'b0;
            strobe_o <= '0;
            ecnt     <= '0;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            total_q  <= EDGE_W'(2 * MIN_BITS);
        end else begin
            strobe_o <= '0;
            if (ph == PH_IDLE) begin
                sclk_o <= cpol_i;
                if (accept_i) begin
                    ph      <= PH_RUN;
                    cpol_q  <= cpol_i;
                    cpha_q  <= cpha_i;
                    total_q <= total_d;
                    ecnt    <= '0;
                end
            end else if (edge_i) begin
                sclk_o          <= ~sclk_o;
                ecnt            <= nxt;
                strobe_o.sample <= cpha_q ? !leading : leading;
                strobe_o.launch <= cpha_q ? leading : (!leading && !last);
                strobe_o.tick   <= !leading;
                strobe_o.done   <= last;
                if (last) ph <= PH_IDLE;
            end
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(strobe_o.launch && strobe_o.sample)); // R9

    AST_STROBE_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (strobe_o.launch || strobe_o.sample || strobe_o.tick) |-> (sclk_o != $past(sclk_o))); // R6

    AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (rst)
        strobe_o.done |-> (!busy_o && sclk_o == cpol_q)); // R5

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> (sclk_o == $past(cpol_i))); // R2

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_gen_pkg::*;
#(
    parameter int PRE_W  = PRE_W_DEF,
    parameter int RATE_W = RATE_W_DEF,
    parameter int LEN_W  = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PRE_W-1:0]  prescale_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic [LEN_W-1:0]  bits_i,
    input  logic              start_i,
    output logic              sclk_o,
    output logic              launch_o,
    output logic              sample_o,
    output logic              bit_tick_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam int HALF_W = PRE_W - 1;

    logic [HALF_W-1:0] half_d, half_q;
    logic [RATE_W-1:0] rate_q;
    logic              accept, pre_tick, sclk_edge, busy;
    strobe_t           strobe;

    assign half_d = HALF_W'(half_prescale(16'(prescale_i)));
    assign accept = start_i && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HALF_W'(1);
            rate_q <= '0;
        end else if (accept) begin
            half_q <= half_d;
            rate_q <= rate_i;
        end
    end

    sclk_prescale #(.HALF_W(HALF_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy),
        .half_i (half_q),
        .tick_o (pre_tick)
    );

    sclk_rate #(.RATE_W(RATE_W)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .run_i   (busy),
        .step_i  (pre_tick),
        .limit_i (rate_q),
        .edge_o  (sclk_edge)
    );

    sclk_edge_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .cpol_i   (cpol_i),
        .cpha_i   (cpha_i),
        .bits_i   (bits_i),
        .edge_i   (sclk_edge),
        .busy_o   (busy),
        .sclk_o   (sclk_o),
        .strobe_o (strobe)
    );

    assign busy_o     = busy;
    assign launch_o   = strobe.launch;
    assign sample_o   = strobe.sample;
    assign bit_tick_o = strobe.tick;
    assign done_o     = strobe.done;

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(rate_q) && $stable(half_q))); // R8

endmodule

// File: tb/sclk_gen_test.sv
module sclk_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] prescale_i = 8'd2;
    logic [7:0] rate_i = 8'd0;
    logic       cpol_i = 1'b0;
    logic       cpha_i = 1'b0;
    logic [4:0] bits_i = 5'd8;
    logic       start_i = 1'b0;
    logic       sclk_o, launch_o, sample_o, bit_tick_o, done_o, busy_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_gen uut (
        .clk(clk), .rst(rst), .prescale_i(prescale_i), .rate_i(rate_i),
        .cpol_i(cpol_i), .cpha_i(cpha_i), .bits_i(bits_i), .start_i(start_i),
        .sclk_o(sclk_o), .launch_o(launch_o), .sample_o(sample_o),
        .bit_tick_o(bit_tick_o), .done_o(done_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1; cpol_i = 1'b1;
        repeat (3) @(negedge clk);
        check(sclk_o == 0 && busy_o == 0 && launch_o == 0 && sample_o == 0
              && bit_tick_o == 0 && done_o == 0, "R1",
              $sformatf("reset outputs sclk=%0b busy=%0b exp 0,0", sclk_o, busy_o));
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic test_idle();
        cpol_i = 1'b1;
        @(negedge clk); @(negedge clk);
        check(sclk_o == 1 && !busy_o && !launch_o && !sample_o, "R2",
              $sformatf("idle sclk=%0b exp 1", sclk_o));
        cpol_i = 1'b0;
        @(negedge clk);
        check(sclk_o == 0 && !busy_o && !launch_o && !sample_o, "R2",
              $sformatf("idle sclk=%0b exp 0", sclk_o));
    endtask

    task automatic run_frame(input string tag, input int pre, input int rate,
                             input int bits, input bit pol, input bit pha,
                             input bit disturb);
        int h, hp, n, e_tot, last_k;
        int e_t, e_s, e_k, e_d;
        string m_t, m_s, m_k, m_d;
        h  = (pre >> 1) == 0 ? 1 : (pre >> 1);
        hp = h * (rate + 1);
        n  = bits < 4 ? 4 : (bits > 16 ? 16 : bits);
        e_tot = 2 * n;
        last_k = e_tot * hp + 3;
        e_t = 0; e_s = 0; e_k = 0; e_d = 0;
        m_t = ""; m_s = ""; m_k = ""; m_d = "";
        @(negedge clk);
        prescale_i = 8'(pre); rate_i = 8'(rate); bits_i = 5'(bits);
        cpol_i = pol; cpha_i = pha; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= last_k; k++) begin
            bit is_edge, lead, x_sclk, x_busy, x_smp, x_lch, x_tick, x_done;
            int e, so_far;
            @(negedge clk);
            e      = k / hp;
            is_edge = (k % hp == 0) && (e <= e_tot);
            so_far = e > e_tot ? e_tot : e;
            lead   = e[0];
            x_sclk = pol ^ so_far[0];
            x_busy = k < e_tot * hp;
            x_smp  = is_edge && (pha ? !lead : lead);
            x_lch  = is_edge && (pha ? lead : (!lead && e < e_tot));
            x_tick = is_edge && !lead;
            x_done = is_edge && (e == e_tot);
            if ((sclk_o != x_sclk || busy_o != x_busy) && e_t++ == 0)
                m_t = $sformatf("k=%0d sclk=%0b busy=%0b exp %0b %0b", k, sclk_o, busy_o, x_sclk, x_busy);
            if ((sample_o != x_smp || launch_o != x_lch) && e_s++ == 0)
                m_s = $sformatf("k=%0d sample=%0b launch=%0b exp %0b %0b", k, sample_o, launch_o, x_smp, x_lch);
            if (bit_tick_o != x_tick && e_k++ == 0)
                m_k = $sformatf("k=%0d tick=%0b exp %0b", k, bit_tick_o, x_tick);
            if (done_o != x_done && e_d++ == 0)
                m_d = $sformatf("k=%0d done=%0b exp %0b", k, done_o, x_done);
            if (disturb && k == 2) begin
                start_i = 1'b1; prescale_i = 8'd40; rate_i = 8'd9;
                cpol_i = !pol; cpha_i = !pha; bits_i = 5'd7;
            end
            if (disturb && k == 3) begin
                start_i = 1'b0; prescale_i = 8'(pre); rate_i = 8'(rate);
                cpol_i = pol; cpha_i = pha; bits_i = 5'(bits);
            end
        end
        check(e_t == 0, {tag, " R3"}, m_t);
        check(e_s == 0, {tag, " R6 R9"}, m_s);
        check(e_k == 0, {tag, " R7"}, m_k);
        check(e_d == 0, {tag, " R5"}, m_d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_idle();
        run_frame("R3 fastest",   2,   0,  8, 0, 0, 0);
        run_frame("R3 mode1",     4,   2,  5, 1, 0, 0);
        run_frame("R6 mode2",     6,   1, 16, 0, 1, 0);
        run_frame("R6 mode3",     2,   3,  4, 1, 1, 0);
        run_frame("R4 odd pre",   7,   0,  4, 0, 0, 0);
        run_frame("R4 pre1",      1,   1,  4, 1, 1, 0);
        run_frame("R4 pre0",      0,   2,  4, 0, 1, 0);
        run_frame("R5 short",     2,   0,  1, 0, 0, 0);
        run_frame("R5 long",      2,   0, 31, 1, 1, 0);
        run_frame("R3 max pre", 254,   0,  4, 0, 0, 0);
        run_frame("R3 max rate",  2, 255,  4, 1, 0, 0);
        run_frame("R8 disturb",   4,   1,  6, 0, 1, 1);
        test_idle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule